// File: doc/BRIEF.md
# Bit-Programmable Nonvolatile Store Sequencer

This block sequences access to a 128-bit nonvolatile array that can only be programmed one bit at a time, and only towards 1. A command receiver hands it one decoded request per clock: whole-array erase, arm-and-set of a single bit, release of that bit, or a one-bit read. The high-voltage parts are replaced by a program timer, which holds the array busy for a long, parameterised number of cycles after each erase or bit set. A second timer enforces a settling gap after each release before the next bit may be set.

The array is organised as eight 16-bit words in which the upper four positions of each word are reserved and must stay 0. Every setting of a bit is a pair of commands: an arm (which sets the bit and starts the program timer) followed by a matching release at the same address. Any request that breaks the protocol is dropped and latches a sticky error flag. Erases are counted, and once the wear limit is reached no further erase is carried out.

Top module: `bit_store_seq`

## Requirements
- R1: After reset, busy, rdValid, rdBit, errSticky and wornOut are 0, eraseCount is 0, and every array bit reads 0.
- R2: Command codes on cmdOp are 0 = idle, 1 = erase, 2 = arm-and-set, 3 = release, 4 = read; codes 5 to 7 act as idle. An accepted arm-and-set makes the addressed bit read 1 and leaves all other bits unchanged; an accepted read raises rdValid for one cycle starting at the clock edge that samples it, with rdBit holding the addressed bit.
- R3: An accepted erase or arm-and-set holds busy high for exactly PROG_CYC cycles, starting at the edge that samples the command.
- R4: Any non-idle command sampled while busy is high is dropped and sets errSticky; the array is not touched.
- R5: Erase, arm-and-set and release are silently ignored (no busy, no change, no error) unless wrEn and chipSel are both high; read does not need them.
- R6: An accepted erase clears all 128 bits to 0 and increments eraseCount by one.
- R7: An arm-and-set sampled within GUARD_CYC cycles after an accepted release (that is, at any of the GUARD_CYC edges following it) is dropped and sets errSticky.
- R8: A release is accepted only if an arm-and-set is pending at the same address; otherwise it is dropped, sets errSticky and keeps any pending arm. An arm-and-set while another is still pending is dropped and sets errSticky.
- R9: An arm-and-set to a reserved position (address bits [3:0] equal to 12 to 15) is dropped and sets errSticky; the bit stays 0.
- R10: eraseCount saturates at ERASE_MAX; wornOut is high once it equals ERASE_MAX, and an erase requested then is dropped and sets errSticky.
- R11: errSticky stays high until reset once set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdOp | input | 3 | Command code, one per cycle |
| cmdAddr | input | 7 | Bit address for arm, release and read |
| wrEn | input | 1 | Write/erase permission level |
| chipSel | input | 1 | Device select level |
| busy | output | 1 | Program/erase timer running |
| rdValid | output | 1 | One-cycle read result strobe |
| rdBit | output | 1 | Read result |
| errSticky | output | 1 | Latched protocol violation |
| eraseCount | output | 7 | Erase cycles performed, saturating |
| wornOut | output | 1 | Erase limit reached |

## Verification
A program timer that runs too long or short shows directly as the width of busy, counted cycle by cycle after a single arm. A wrong pending-arm or guard state shows in the errSticky level one edge after the offending release or arm, and a spurious or missing bit set shows at the very next read, one cycle after it is sampled. A wrong erase count is visible on eraseCount immediately and on wornOut at the hundredth erase.

// File: rtl/bitstore_pkg.sv
package bitstore_pkg;
  localparam int STORE_BITS = 128;
  localparam int ADDR_W     = $clog2(STORE_BITS);
  localparam int WORD_BITS  = 16;
  localparam int RSV_BITS   = 4;
  localparam int USE_BITS   = WORD_BITS - RSV_BITS;
  localparam int WIDX       = $clog2(WORD_BITS);

  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_ERASE = 3'd1,
    OP_ARM   = 3'd2,
    OP_REL   = 3'd3,
    OP_READ  = 3'd4
  } op_e;

  typedef struct packed {
    logic              doErase;
    logic              doSet;
    logic              doRead;
    logic [ADDR_W-1:0] addr;
  } strobe_t;
endpackage

// File: rtl/bitstore_ctrl.sv
module bitstore_ctrl
  import bitstore_pkg::*;
#(
  parameter int PROG_CYC  = 50000,
  parameter int GUARD_CYC = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              wrEn,
  input  logic              chipSel,
  input  logic              wornOut,
  output strobe_t           strb,
  output logic              busy,
  output logic              rdValid,
  output logic              errSticky
);
  localparam int PCW = $clog2(PROG_CYC + 1);
  localparam int GCW = $clog2(GUARD_CYC + 1);

  logic [PCW-1:0]    progCnt;
  logic [GCW-1:0]    guardCnt;
  logic              armed;
  logic [ADDR_W-1:0] armAddr;
  logic              errHit, relOk, enOk, reserved, guardOn;

  assign busy     = (progCnt != '0);
  assign guardOn  = (guardCnt != '0);
  assign enOk     = wrEn && chipSel;
  assign reserved = (cmdAddr[WIDX-1:0] >= WIDX'(USE_BITS));

  always_comb begin
    strb      = '0;
    strb.addr = cmdAddr;
    errHit    = 1'b0;
    relOk     = 1'b0;
    if (cmdOp inside {OP_ERASE, OP_ARM, OP_REL, OP_READ}) begin
      if (busy) errHit = 1'b1;
      else begin
        case (cmdOp)
          OP_READ:  strb.doRead = 1'b1;
          OP_ERASE: if (enOk) begin
                      if (wornOut) errHit = 1'b1;
                      else strb.doErase = 1'b1;
                    end
          OP_ARM:   if (enOk) begin
                      if (guardOn || armed || reserved) errHit = 1'b1;
                      else strb.doSet = 1'b1;
                    end
          OP_REL:   if (enOk) begin
                      if (!armed || cmdAddr != armAddr) errHit = 1'b1;
                      else relOk = 1'b1;
                    end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      progCnt   <= '0;
      guardCnt  <= '0;
      armed     <= 1'b0;
      armAddr   <= '0;
      rdValid   <= 1'b0;
      errSticky <= 1'b0;
    end else begin
      if (strb.doErase || strb.doSet) progCnt <= PCW'(PROG_CYC);
      else if (busy)                  progCnt <= progCnt - PCW'(1);
      if (relOk)        guardCnt <= GCW'(GUARD_CYC);
      else if (guardOn) guardCnt <= guardCnt - GCW'(1);
      if (strb.doSet) begin
        armed   <= 1'b1;
        armAddr <= cmdAddr;
      end else if (relOk || strb.doErase) begin
        armed <= 1'b0;
      end
      rdValid   <= strb.doRead;
      errSticky <= errSticky | errHit;
    end
  end

  a_r3_busy_after_start: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doErase || strb.doSet) |=> busy);
  a_r4_no_op_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !(strb.doErase || strb.doSet || strb.doRead));
  a_r5_enables_required: assert property (@(posedge clk) disable iff (!rstN)
    (strb.doErase || strb.doSet) |-> (wrEn && chipSel));
  a_r7_guard_blocks_arm: assert property (@(posedge clk) disable iff (!rstN)
    guardOn |-> !strb.doSet);
  a_r9_no_reserved_set: assert property (@(posedge clk) disable iff (!rstN)
    strb.doSet |-> (strb.addr[WIDX-1:0] < WIDX'(USE_BITS)));
  a_r11_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errSticky |=> errSticky);
endmodule

// File: rtl/bitstore_array.sv
module bitstore_array
  import bitstore_pkg::*;
#(
  parameter int ERASE_MAX = 100,
  localparam int ECW      = $clog2(ERASE_MAX + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  strobe_t        strb,
  output logic           rdBit,
  output logic [ECW-1:0] eraseCount,
  output logic           wornOut
);
  logic [STORE_BITS-1:0] store;

  assign wornOut = (eraseCount == ECW'(ERASE_MAX));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      store      <= '0;
      eraseCount <= '0;
      rdBit      <= 1'b0;
    end else begin
      if (strb.doErase) begin
        store <= '0;
        if (!wornOut) eraseCount <= eraseCount + ECW'(1);
      end else if (strb.doSet) begin
        store[strb.addr] <= 1'b1;
      end
      if (strb.doRead) rdBit <= store[strb.addr];
    end
  end

  a_r6_erase_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.doErase |=> (store == '0));
  a_r2_bit_set: assert property (@(posedge clk) disable iff (!rstN)
    strb.doSet |=> store[$past(strb.addr)]);
  a_r10_count_bounded: assert property (@(posedge clk) disable iff (!rstN)
    eraseCount <= ECW'(ERASE_MAX));
endmodule

// File: rtl/bit_store_seq.sv
module bit_store_seq
  import bitstore_pkg::*;
#(
  parameter int PROG_CYC  = 50000,
  parameter int GUARD_CYC = 1000,
  parameter int ERASE_MAX = 100
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [2:0]                       cmdOp,
  input  logic [ADDR_W-1:0]                cmdAddr,
  input  logic                             wrEn,
  input  logic                             chipSel,
  output logic                             busy,
  output logic                             rdValid,
  output logic                             rdBit,
  output logic                             errSticky,
  output logic [$clog2(ERASE_MAX+1)-1:0]   eraseCount,
  output logic                             wornOut
);
  strobe_t strb;

  bitstore_ctrl #(.PROG_CYC(PROG_CYC), .GUARD_CYC(GUARD_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .wrEn(wrEn), .chipSel(chipSel), .wornOut(wornOut), .strb(strb),
    .busy(busy), .rdValid(rdValid), .errSticky(errSticky)
  );

  bitstore_array #(.ERASE_MAX(ERASE_MAX)) uArray (
    .clk(clk), .rstN(rstN), .strb(strb), .rdBit(rdBit),
    .eraseCount(eraseCount), .wornOut(wornOut)
  );
endmodule

// File: tb/tb_bit_store_seq.sv
module tb_bit_store_seq;
  localparam int CLK_PERIOD = 10;
  localparam int PROG  = 20;
  localparam int GUARD = 6;
  localparam int EMAX  = 100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] cmdOp = '0;
  logic [6:0] cmdAddr = '0;
  logic wrEn = 1'b1, chipSel = 1'b1;
  logic busy, rdValid, rdBit, errSticky, wornOut;
  logic [6:0] eraseCount;
  int nChk = 0, nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bit_store_seq #(.PROG_CYC(PROG), .GUARD_CYC(GUARD), .ERASE_MAX(EMAX)) dut (
    .clk(clk), .rstN(rstN), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .wrEn(wrEn), .chipSel(chipSel), .busy(busy), .rdValid(rdValid),
    .rdBit(rdBit), .errSticky(errSticky), .eraseCount(eraseCount),
    .wornOut(wornOut)
  );

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; cmdOp = 0; wrEn = 1; chipSel = 1;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] op, input logic [6:0] a);
    cmdOp = op; cmdAddr = a;
    @(negedge clk);
    cmdOp = 0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic readChk(input string req, input logic [6:0] a, input int exp);
    issue(3'd4, a);
    check({req, " rdValid"}, rdValid, 1);
    check({req, " rdBit"}, rdBit, exp);
  endtask

  task automatic setBit(input logic [6:0] a);
    issue(3'd2, a); waitIdle(); issue(3'd3, a);
    repeat (GUARD) @(negedge clk);
  endtask

  task automatic tResetState();
    doReset();
    check("R1 busy", busy, 0);
    check("R1 err", errSticky, 0);
    check("R1 worn", wornOut, 0);
    check("R1 count", eraseCount, 0);
    check("R1 rdValid", rdValid, 0);
    readChk("R1 bit 0", 7'd0, 0);
    readChk("R1 bit 127", 7'd127, 0);
  endtask

  task automatic tSetAndRead();
    doReset();
    setBit(7'd5);
    readChk("R2 bit 5 set", 7'd5, 1);
    @(negedge clk);
    check("R2 rdValid one cycle", rdValid, 0);
    readChk("R2 bit 4 untouched", 7'd4, 0);
    issue(3'd7, 7'd6);
    check("R2 code 7 idle err", errSticky, 0);
    check("R2 code 7 idle busy", busy, 0);
    check("R2 clean protocol", errSticky, 0);
  endtask

  task automatic tBusyWidth();
    int n = 0;
    doReset();
    issue(3'd2, 7'd1);
    while (busy) begin n++; @(negedge clk); end
    check("R3 busy width", n, PROG);
  endtask

  task automatic tBusyDrop();
    doReset();
    issue(3'd2, 7'd7);
    issue(3'd4, 7'd7);
    check("R4 read while busy no rdValid", rdValid, 0);
    check("R4 err on busy cmd", errSticky, 1);
    waitIdle(); issue(3'd3, 7'd7); repeat (GUARD) @(negedge clk);
    readChk("R4 arm still set", 7'd7, 1);
    readChk("R4 other bit clear", 7'd9, 0);
    check("R11 err stays", errSticky, 1);
  endtask

  task automatic tEnables();
    doReset();
    wrEn = 0;
    issue(3'd2, 7'd3);
    check("R5 no busy WE low", busy, 0);
    wrEn = 1; chipSel = 0;
    issue(3'd1, 7'd0);
    check("R5 no busy CS low", busy, 0);
    readChk("R5 read with CS low", 7'd3, 0);
    chipSel = 1;
    check("R5 no err", errSticky, 0);
    check("R5 no erase counted", eraseCount, 0);
  endtask

  task automatic tGuard();
    doReset();
    issue(3'd2, 7'd2); waitIdle(); issue(3'd3, 7'd2);
    repeat (GUARD - 1) @(negedge clk);
    issue(3'd2, 7'd8);
    check("R7 arm at guard end dropped", errSticky, 1);
    check("R7 no busy", busy, 0);
    readChk("R7 bit clear", 7'd8, 0);
    doReset();
    issue(3'd2, 7'd2); waitIdle(); issue(3'd3, 7'd2);
    repeat (GUARD) @(negedge clk);
    issue(3'd2, 7'd8);
    check("R7 arm after guard ok", errSticky, 0);
    check("R7 arm after guard busy", busy, 1);
  endtask

  task automatic tPairing();
    doReset();
    issue(3'd3, 7'd4);
    check("R8 release without arm", errSticky, 1);
    doReset();
    issue(3'd2, 7'd4); waitIdle();
    issue(3'd3, 7'd5);
    check("R8 mismatched release", errSticky, 1);
    doReset();
    issue(3'd2, 7'd4); waitIdle();
    issue(3'd2, 7'd6);
    check("R8 second arm dropped", errSticky, 1);
    check("R8 second arm no busy", busy, 0);
    issue(3'd3, 7'd4);
    repeat (GUARD) @(negedge clk);
    issue(3'd2, 7'd6);
    check("R8 arm after matched release busy", busy, 1);
  endtask

  task automatic tReserved();
    doReset();
    issue(3'd2, 7'd12);
    check("R9 reserved err", errSticky, 1);
    check("R9 reserved no busy", busy, 0);
    readChk("R9 reserved bit 0", 7'd12, 0);
    doReset();
    issue(3'd2, 7'd127);
    check("R9 reserved top err", errSticky, 1);
    doReset();
    issue(3'd2, 7'd27);
    check("R9 usable 27 accepted", busy, 1);
  endtask

  task automatic tErase();
    doReset();
    setBit(7'd0); setBit(7'd100);
    issue(3'd1, 7'd0);
    check("R6 erase busy", busy, 1);
    waitIdle();
    check("R6 count 1", eraseCount, 1);
    readChk("R6 bit 0 cleared", 7'd0, 0);
    readChk("R6 bit 100 cleared", 7'd100, 0);
  endtask

  task automatic tWear();
    doReset();
    for (int i = 0; i < EMAX - 1; i++) begin issue(3'd1, 7'd0); waitIdle(); end
    check("R10 count 99", eraseCount, EMAX - 1);
    check("R10 not worn at 99", wornOut, 0);
    issue(3'd1, 7'd0); waitIdle();
    check("R10 count max", eraseCount, EMAX);
    check("R10 worn", wornOut, 1);
    check("R10 no err yet", errSticky, 0);
    issue(3'd1, 7'd0);
    check("R10 extra erase err", errSticky, 1);
    check("R10 extra erase no busy", busy, 0);
    check("R10 count saturated", eraseCount, EMAX);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    @(negedge clk);
    tResetState();
    tSetAndRead();
    tBusyWidth();
    tBusyDrop();
    tEnables();
    tGuard();
    tPairing();
    tReserved();
    tErase();
    tWear();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule